// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Level-Gated Writes

This block is a two-wire bus slave that fronts a 128-byte internal memory. It follows the bus in bidirectional mode. It finds START and STOP conditions and checks the device code in the address byte. It accepts a word address, then serves byte writes, current-address reads and random reads. The bus lines arrive already synchronized to the system clock. The block answers only by pulling SDA low through an open-drain output.

Writes are gated by a separate level input, `wr_en_i`, which reuses the display clock pin as a write enable. A byte received in a write command is held in a buffer. When the master sends STOP with the enable high, a self-timed commit starts. The commit runs for a fixed number of clocks and stores the byte when it ends. Once a commit has started, the enable no longer affects it. While the commit is running, the slave ignores its own address, so a master can poll for completion.

Top module: `eeslv_top`

## Requirements
- R1: SDA falling while SCL is high is a START. Before the first START, all bus activity is ignored and no acknowledge is given. A START releases SDA and begins a new address byte.
- R2: SDA rising while SCL is high is a STOP. It ends any command, and bits that follow without a new START get no acknowledge.
- R3: The address byte is acknowledged only when bits 7:4 equal 1010. Bits 3:1 have no effect.
- R4: Address bit 0 selects the direction: 1 is a read and 0 is a write. A random read is a write of the word address, then a repeated START and a read.
- R5: A STOP after a buffered data byte, with `wr_en_i` high, raises `busy_o` for exactly WR_CYCLES clocks. The byte is stored when `busy_o` ends.
- R6: While `busy_o` is high, the device address is not acknowledged.
- R7: If `wr_en_i` is low at the STOP, nothing is stored and `busy_o` stays low.
- R8: A commit that has started finishes even if `wr_en_i` falls while it runs.
- R9: The slave pulls SDA low in the ninth clock slot to acknowledge the address byte, the word address and the first data byte. A second data byte in the same command is not acknowledged and is discarded.
- R10: Only the low 7 bits of the word address are used. The internal pointer steps after each byte read or written and wraps from 127 to 0.
- R11: Read data goes out MSB first. If the master acknowledges, the next byte follows. If it does not, the slave releases SDA and sends nothing more.
- R12: `sda_pull_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| wr_en_i | input | 1 | Write enable level (high allows writes) |
| sda_pull_o | output | 1 | Drives the bus data line low when high |
| busy_o | output | 1 | Self-timed commit in progress |

## Verification
The checker watches every cycle for these properties:
- A START releases the data line.
- The data output changes only while SCL is low.
- SDA is driven only in acknowledge slots or read-data slots.
- `busy_o` rises only just after a STOP with the enable high, and then holds until the memory write.
- The address is never acknowledged during a commit.

The bench scenarios cover what needs whole transactions to see:
- the device-code match, including the don't-care bits
- the commit length
- gated and in-flight writes
- the single-byte write limit
- pointer stepping and wrap
- release of the line after a master's not-acknowledge

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WADR, S_WADR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
  } bus_state_e;

  function automatic logic code_hit(input logic [DATA_W-1:0] b);
    return b[DATA_W-1 -: 4] == DEV_CODE;
  endfunction
endpackage

// File: rtl/eeslv_line_events.sv
module eeslv_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign ev_start = scl_i & scl_q & sda_q & ~sda_i;
  assign ev_stop  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eeslv_array.sv
module eeslv_array #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeslv_commit_timer.sv
module eeslv_commit_timer #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else if (start && cnt == '0) begin
      cnt       <= LOAD;
      mem_waddr <= addr;
      mem_wdata <= data;
    end else if (cnt != '0) begin
      cnt <= cnt - LAST;
    end
  end

  assign busy   = cnt != '0;
  assign mem_we = cnt == LAST;
endmodule

// File: rtl/eeslv_top.sv
module eeslv_top
  import eeslv_pkg::*;
#(
  parameter int WR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_en_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  logic scl_rise, scl_fall, ev_start, ev_stop;
  logic mem_we, commit_go;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  bus_state_e        state;
  logic [3:0]        bit_cnt;
  logic [DATA_W-1:0] shreg, tx_sh, wbuf;
  logic [ADDR_W-1:0] ptr, wadr;
  logic              wpend, ack_pull, rd_dir, mack;
  logic              byte_done, dev_ack_go, rd_drive;

  eeslv_line_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  eeslv_commit_timer #(.AW(ADDR_W), .DW(DATA_W), .CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_go), .addr(wadr), .data(wbuf),
    .busy(busy_o), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eeslv_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(ptr), .rdata(mem_rdata)
  );

  assign byte_done  = scl_fall && bit_cnt == LAST_BIT;
  assign dev_ack_go = code_hit(shreg) && !busy_o;
  assign commit_go  = ev_stop && wpend && wr_en_i;
  assign rd_drive   = (state == S_RDAT) && !tx_sh[DATA_W-1];
  assign sda_pull_o = ack_pull | rd_drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      wbuf     <= '0;
      ptr      <= '0;
      wadr     <= '0;
      wpend    <= 1'b0;
      ack_pull <= 1'b0;
      rd_dir   <= 1'b0;
      mack     <= 1'b0;
    end else if (ev_start) begin
      state    <= S_DEV;
      bit_cnt  <= '0;
      ack_pull <= 1'b0;
      wpend    <= 1'b0;
    end else if (ev_stop) begin
      state    <= S_IDLE;
      ack_pull <= 1'b0;
      wpend    <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise) begin
            shreg   <= {shreg[DATA_W-2:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == S_DEV) begin
              if (dev_ack_go) begin
                ack_pull <= 1'b1;
                rd_dir   <= shreg[0];
                state    <= S_DEV_ACK;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_WADR) begin
              ack_pull <= 1'b1;
              wadr     <= shreg[ADDR_W-1:0];
              state    <= S_WADR_ACK;
            end else begin
              ack_pull <= 1'b1;
              wbuf     <= shreg;
              wpend    <= 1'b1;
              state    <= S_WDAT_ACK;
            end
          end
        end
        S_DEV_ACK: if (scl_fall) begin
          ack_pull <= 1'b0;
          bit_cnt  <= '0;
          if (rd_dir) begin
            tx_sh <= mem_rdata;
            ptr   <= ptr_next(ptr);
            state <= S_RDAT;
          end else begin
            state <= S_WADR;
          end
        end
        S_WADR_ACK: if (scl_fall) begin
          ack_pull <= 1'b0;
          ptr      <= wadr;
          state    <= S_WDAT;
        end
        S_WDAT_ACK: if (scl_fall) begin
          ack_pull <= 1'b0;
          ptr      <= ptr_next(ptr);
          state    <= S_IDLE;
        end
        S_RDAT: if (scl_fall) begin
          tx_sh   <= {tx_sh[DATA_W-2:0], 1'b1};
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd7) state <= S_RACK;
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_i;
          else if (scl_fall) begin
            bit_cnt <= '0;
            if (mack) begin
              tx_sh <= mem_rdata;
              ptr   <= ptr_next(ptr);
              state <= S_RDAT;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeslv_checker.sv
module eeslv_checker
  import eeslv_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       wr_en_i,
  input logic       sda_pull_o,
  input logic       busy_o,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       mem_we,
  input bus_state_e state
);
  assert_start_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_pull_o);

  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(ev_stop) && $past(wr_en_i)));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mem_we) |=> busy_o);

  assert_store_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy_o);

  assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV_ACK) |-> !busy_o);

  assert_pull_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (state inside {S_DEV_ACK, S_WADR_ACK, S_WDAT_ACK, S_RDAT}));

  assert_change_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind eeslv_top eeslv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wr_en_i(wr_en_i),
  .sda_pull_o(sda_pull_o), .busy_o(busy_o), .ev_start(ev_start),
  .ev_stop(ev_stop), .mem_we(mem_we), .state(state)
);

// File: tb/test_eeslv_top.sv
module test_eeslv_top;
  localparam int WR = 300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, sda_m, wr_en;
  wire  sda_pull, busy;
  wire  sda_line = sda_m & ~sda_pull;

  eeslv_top #(.WR_CYCLES(WR)) i_eeslv_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wr_en_i(wr_en), .sda_pull_o(sda_pull), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string tag; logic [7:0] v; } item_t;
  item_t       exp_q[$];
  logic [7:0]  obs_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops observed items against the expected queue
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e;
      logic [7:0] o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      check(e.tag, {24'd0, o}, {24'd0, e.v});
    end
  end

  int run = 0, last_run = 0;
  always @(negedge clk) begin
    if (busy) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; tick(3);
    scl = 1'b1; tick(3);
    s = sda_line; tick(3);
    scl = 1'b0; tick(2);
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(3); scl = 1'b1; tick(3);
    sda_m = 1'b0; tick(3); scl = 1'b0; tick(2);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(3); scl = 1'b1; tick(3);
    sda_m = 1'b1; tick(3);
  endtask

  // ack observed as 1 = acknowledged (line low in ninth slot)
  task automatic send(input logic [7:0] b, input string tag, input logic exp_ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    exp_q.push_back('{tag, {7'd0, exp_ack}});
    obs_q.push_back({7'd0, ~s});
  endtask

  task automatic recv(input logic m_ack, input logic [7:0] expv, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); got[i] = s; end
    bus_bit(~m_ack, s);
    exp_q.push_back('{tag, expv});
    obs_q.push_back(got);
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d, input string tag);
    start_c(); send(8'hA0, tag, 1'b1); send(a, tag, 1'b1); send(d, tag, 1'b1); stop_c();
  endtask

  task automatic rd_rand(input logic [7:0] a, input logic [7:0] expv, input string tag);
    start_c(); send(8'hA0, tag, 1'b1); send(a, tag, 1'b1);
    start_c(); send(8'hA1, tag, 1'b1); recv(1'b0, expv, tag); stop_c();
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(2);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    logic s;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; wr_en = 1'b1;
    tick(5);
    check("R1 reset pull", {31'd0, sda_pull}, 32'd0);
    check("R5 reset busy", {31'd0, busy}, 32'd0);
    rst_n = 1'b1; tick(3);

    // R1: no START yet -> ignored
    send(8'hA0, "R1 before start", 1'b0); stop_c();

    // R2: STOP mid-address, then bits without START are ignored
    start_c(); bus_bit(1'b1, s); bus_bit(1'b0, s); stop_c();
    send(8'hA0, "R2 after stop", 1'b0); stop_c();

    // R5/R6/R9: byte write, poll while busy
    wr_byte(8'h05, 8'h3C, "R9 write acks");
    check("R5 busy after stop", {31'd0, busy}, 32'd1);
    start_c(); send(8'hA0, "R6 no ack while busy", 1'b0); stop_c();
    wait_idle();
    check("R5 busy length", last_run, WR);
    rd_rand(8'h05, 8'h3C, "R4 R5 random read");

    // R3: don't-care bits and mismatched codes
    start_c(); send(8'hAE, "R3 dont care", 1'b1); send(8'h05, "R3", 1'b1);
    start_c(); send(8'hAF, "R3 dont care rd", 1'b1); recv(1'b0, 8'h3C, "R4 read dir"); stop_c();
    start_c(); send(8'hB0, "R3 mismatch B", 1'b0); stop_c();
    start_c(); send(8'h20, "R3 mismatch 2", 1'b0); stop_c();

    // R7: gated write
    wr_en = 1'b0;
    wr_byte(8'h06, 8'h55, "R7 gated acks");
    tick(2);
    check("R7 no busy", {31'd0, busy}, 32'd0);
    wr_en = 1'b1;
    rd_rand(8'h06, 8'h00, "R7 unchanged");

    // R8: enable drops during commit
    wr_byte(8'h07, 8'hA5, "R8 write");
    tick(5); wr_en = 1'b0;
    wait_idle(); wr_en = 1'b1;
    rd_rand(8'h07, 8'hA5, "R8 completed");

    // R9: second data byte refused
    start_c(); send(8'hA0, "R9", 1'b1); send(8'h08, "R9", 1'b1);
    send(8'h11, "R9 first data", 1'b1); send(8'h22, "R9 second data nack", 1'b0); stop_c();
    wait_idle();
    rd_rand(8'h08, 8'h11, "R9 first stored");
    rd_rand(8'h09, 8'h00, "R9 second discarded");

    // R10: high address bit ignored, wrap 127 -> 0, pointer after write
    wr_byte(8'hFF, 8'h9E, "R10 write 7F"); wait_idle();
    wr_byte(8'h01, 8'h77, "R10 write 01"); wait_idle();
    wr_byte(8'h00, 8'h4D, "R10 write 00"); wait_idle();
    start_c(); send(8'hA1, "R10 current", 1'b1); recv(1'b0, 8'h77, "R10 ptr after write"); stop_c();
    start_c(); send(8'hA0, "R10", 1'b1); send(8'h7F, "R10", 1'b1);
    start_c(); send(8'hA1, "R10", 1'b1);
    recv(1'b1, 8'h9E, "R11 first byte");
    recv(1'b0, 8'h4D, "R10 wrap");
    bus_bit(1'b1, s);
    tick(1);
    check("R11 released after nack", {31'd0, s}, 32'd1);
    stop_c();

    tick(4);
    check("R11 queue drained", exp_q.size(), 0);
    report();
  end
endmodule